// File: doc/BRIEF.md
# RNG Continuous Health Test Monitor

This block sits beside a hardware random source and checks its output as it is produced. It watches two streams: the raw entropy bits, one per cycle when the bit strobe is high, and the finished output words, one per cycle when the word strobe is high. Four tests run side by side. The first counts ones over a fixed window and judges the total at the end of the window. The second and third are repetition detectors with different run lengths. The fourth flags an output word that equals the word before it.

Each test reports through its own single-cycle failure pulse. Latching, masking and acknowledging these events is the job of the surrounding status logic. An enable input freezes the whole monitor. A clear input restarts every counter and forgets the stored word, so a fresh window and a fresh run begin with the next accepted input.

Top module: `rng_health_mon`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, all four failure pulses are low.
- R2: The ones-window test counts the ones among WIN_BITS (20000) accepted bits. The pulse `fail_ones_o` goes high for one cycle after the last bit of a window when the count is below ONES_LO (9655) or above ONES_HI (10345). Counts equal to either bound pass.
- R3: The bit and ones counters start again from zero after each window ends, so one window's result does not affect the next.
- R4: `fail_longrun_o` pulses for one cycle after the accepted bit that makes a run of LONG_RUN (34) identical consecutive bits, and only once per run however long the run lasts.
- R5: `fail_noise_o` pulses for one cycle after the accepted bit that makes a run of NOISE_RUN (48) identical consecutive bits, once per run.
- R6: An accepted bit that differs from the previous accepted bit starts a new run of length 1. The first bit after reset or clear also starts a run of length 1.
- R7: `fail_stuck_o` pulses for one cycle after an accepted word equal to the previous accepted word.
- R8: The first word accepted after reset or clear is never flagged.
- R9: With `en_i` low, no input is accepted, every counter and the stored word hold, and no failure pulse is produced in the following cycle.
- R10: A high `clr_i` zeroes all counters and forgets the stored word, regardless of `en_i`. The inputs of that cycle are discarded and no pulse follows.
- R11: Each failure pulse is registered. It appears in the cycle after the clock edge that accepts the triggering input and lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Monitor enable; when low, the monitor holds its state |
| clr_i | input | 1 | Synchronous restart of all tests |
| bit_i | input | 1 | Raw entropy bit |
| bit_vld_i | input | 1 | `bit_i` carries a new bit this cycle |
| word_i | input | WORD_W | Completed output word |
| word_vld_i | input | 1 | `word_i` carries a new word this cycle |
| fail_ones_o | output | 1 | Ones-window test failure pulse |
| fail_longrun_o | output | 1 | Long-run repetition failure pulse |
| fail_noise_o | output | 1 | Noise repetition failure pulse |
| fail_stuck_o | output | 1 | Repeated-output-word failure pulse |

## Verification
A run counter that is off by one shows at the ports as a repetition pulse one bit early or late, on the first long run after the fault. A missed restart shows as no pulse at all, or as a second pulse in the same run. A bit or ones counter that drifts is only visible at the next window boundary, up to 20000 bits later. For that reason the bench aligns whole windows to exact ones counts on both sides of each bound. A stored word or valid flag that is not cleared shows on the first word after a clear, as a false stuck pulse.

// File: rtl/rng_hm_pkg.sv
package rng_hm_pkg;

  function automatic int cnt_w(input int max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rhm_run_track.sv
module rhm_run_track
  import rng_hm_pkg::*;
#(
  parameter int RUN_MAX = 48,
  localparam int SAT    = RUN_MAX + 1,
  localparam int RW     = cnt_w(SAT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          step_i,
  input  logic          bit_i,
  output logic [RW-1:0] run_next_o
);

  logic          have_q, have_d;
  logic          prev_q, prev_d;
  logic [RW-1:0] run_q, run_d;
  logic          upd;

  always_comb begin
    have_d = have_q;
    prev_d = prev_q;
    run_d  = run_q;
    if (clr_i) begin
      have_d = 1'b0;
      prev_d = 1'b0;
      run_d  = '0;
    end else if (step_i) begin
      have_d = 1'b1;
      prev_d = bit_i;
      if (have_q && (bit_i == prev_q)) begin
        run_d = (run_q == RW'(SAT)) ? run_q : run_q + RW'(1);
      end else begin
        run_d = RW'(1);
      end
    end
  end

  assign upd        = clr_i | step_i;
  assign run_next_o = run_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q <= 1'b0;
      prev_q <= 1'b0;
      run_q  <= '0;
    end else if (upd) begin
      have_q <= have_d;
      prev_q <= prev_d;
      run_q  <= run_d;
    end
  end

  // R6: a differing bit restarts the run at one
  p_run_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !clr_i && have_q && (bit_i != prev_q)) |=> (run_q == RW'(1)));

  // R4: an equal bit below saturation extends the run by exactly one
  p_run_extend_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !clr_i && have_q && (bit_i == prev_q) && (run_q < RW'(SAT)))
      |=> (run_q == $past(run_q) + RW'(1)));

  // R9: without a step or clear the run length holds
  p_run_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !clr_i) |=> $stable(run_q));

endmodule

// File: rtl/rhm_run_thresh.sv
module rhm_run_thresh #(
  parameter int THR = 34,
  parameter int RW  = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_i,
  input  logic [RW-1:0] run_i,
  output logic          fail_o
);

  logic fail_q, fail_d;

  always_comb begin
    fail_d = step_i && (run_i == RW'(THR));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_q <= 1'b0;
    end else begin
      fail_q <= fail_d;
    end
  end

  assign fail_o = fail_q;

  // R11: a repetition pulse never lasts more than one cycle
  p_single_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fail_q |=> !fail_q);

endmodule

// File: rtl/rhm_ones_window.sv
module rhm_ones_window
  import rng_hm_pkg::*;
#(
  parameter int WIN     = 20000,
  parameter int ONES_LO = 9655,
  parameter int ONES_HI = 10345,
  localparam int CW     = cnt_w(WIN)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic step_i,
  input  logic bit_i,
  output logic fail_o
);

  logic [CW-1:0] bit_cnt_q, bit_cnt_d;
  logic [CW-1:0] ones_q, ones_d;
  logic [CW-1:0] ones_sum;
  logic          last_bit;
  logic          fail_q, fail_d;
  logic          upd;

  always_comb begin
    ones_sum  = ones_q + CW'(bit_i);
    last_bit  = (bit_cnt_q == CW'(WIN - 1));
    bit_cnt_d = bit_cnt_q;
    ones_d    = ones_q;
    fail_d    = 1'b0;
    if (clr_i) begin
      bit_cnt_d = '0;
      ones_d    = '0;
    end else if (step_i) begin
      if (last_bit) begin
        bit_cnt_d = '0;
        ones_d    = '0;
        fail_d    = (ones_sum < CW'(ONES_LO)) || (ones_sum > CW'(ONES_HI));
      end else begin
        bit_cnt_d = bit_cnt_q + CW'(1);
        ones_d    = ones_sum;
      end
    end
  end

  assign upd = clr_i | step_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt_q <= '0;
      ones_q    <= '0;
    end else if (upd) begin
      bit_cnt_q <= bit_cnt_d;
      ones_q    <= ones_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_q <= 1'b0;
    end else begin
      fail_q <= fail_d;
    end
  end

  assign fail_o = fail_q;

  // R3: the ones count can never exceed the bits seen in the window
  p_ones_le_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ones_q <= bit_cnt_q);

  // R3: the window counter stays inside the window
  p_cnt_in_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt_q < CW'(WIN));

  // R2: a verdict only follows the last bit of a window
  p_verdict_at_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fail_q |-> (bit_cnt_q == '0));

endmodule

// File: rtl/rhm_stuck_word.sv
module rhm_stuck_word #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              step_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              fail_o
);

  logic              have_q, have_d;
  logic [WORD_W-1:0] prev_q, prev_d;
  logic              fail_q, fail_d;
  logic              upd;

  always_comb begin
    have_d = have_q;
    prev_d = prev_q;
    fail_d = 1'b0;
    if (clr_i) begin
      have_d = 1'b0;
      prev_d = '0;
    end else if (step_i) begin
      fail_d = have_q && (word_i == prev_q);
      have_d = 1'b1;
      prev_d = word_i;
    end
  end

  assign upd = clr_i | step_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q <= 1'b0;
      prev_q <= '0;
    end else if (upd) begin
      have_q <= have_d;
      prev_q <= prev_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_q <= 1'b0;
    end else begin
      fail_q <= fail_d;
    end
  end

  assign fail_o = fail_q;

  // R8: the first word after reset or clear is never flagged
  p_first_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !clr_i && !have_q) |=> !fail_q);

  // R10: clear forgets the stored word
  p_clear_forgets_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !have_q);

endmodule

// File: rtl/rng_health_mon.sv
module rng_health_mon
  import rng_hm_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int WIN_BITS  = 20000,
  parameter int ONES_LO   = 9655,
  parameter int ONES_HI   = 10345,
  parameter int LONG_RUN  = 34,
  parameter int NOISE_RUN = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              clr_i,
  input  logic              bit_i,
  input  logic              bit_vld_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              word_vld_i,
  output logic              fail_ones_o,
  output logic              fail_longrun_o,
  output logic              fail_noise_o,
  output logic              fail_stuck_o
);

  localparam int RUN_MAX = max2(LONG_RUN, NOISE_RUN);
  localparam int RW      = cnt_w(RUN_MAX + 1);
  localparam int N_THR   = 2;
  localparam int RUN_THR [N_THR] = '{LONG_RUN, NOISE_RUN};

  logic          bit_take;
  logic          word_take;
  logic [RW-1:0] run_next;
  logic [N_THR-1:0] run_fail;

  assign bit_take  = en_i & bit_vld_i & ~clr_i;
  assign word_take = en_i & word_vld_i & ~clr_i;

  rhm_ones_window #(
    .WIN     (WIN_BITS),
    .ONES_LO (ONES_LO),
    .ONES_HI (ONES_HI)
  ) u_ones (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (clr_i),
    .step_i (bit_take),
    .bit_i  (bit_i),
    .fail_o (fail_ones_o)
  );

  rhm_run_track #(
    .RUN_MAX (RUN_MAX)
  ) u_run (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (clr_i),
    .step_i     (bit_take),
    .bit_i      (bit_i),
    .run_next_o (run_next)
  );

  for (genvar g = 0; g < N_THR; g++) begin : g_thr
    rhm_run_thresh #(
      .THR (RUN_THR[g]),
      .RW  (RW)
    ) u_thr (
      .clk    (clk),
      .rst_n  (rst_n),
      .step_i (bit_take),
      .run_i  (run_next),
      .fail_o (run_fail[g])
    );
  end

  assign fail_longrun_o = run_fail[0];
  assign fail_noise_o   = run_fail[1];

  rhm_stuck_word #(
    .WORD_W (WORD_W)
  ) u_stuck (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (clr_i),
    .step_i (word_take),
    .word_i (word_i),
    .fail_o (fail_stuck_o)
  );

  // R9: a disabled cycle is followed by a quiet cycle
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !(fail_ones_o | fail_longrun_o | fail_noise_o | fail_stuck_o));

  // R10: a clear cycle is followed by a quiet cycle
  p_clear_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !(fail_ones_o | fail_longrun_o | fail_noise_o | fail_stuck_o));

  // R4: the two repetition detectors never fire on the same bit
  p_thr_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fail_longrun_o, fail_noise_o}));

endmodule

// File: tb/rng_health_mon_tb_top.sv
`timescale 1ns/1ps
module rng_health_mon_tb_top;

  localparam int WIN  = 20000;
  localparam int LO   = 9655;
  localparam int HI   = 10345;
  localparam int LRUN = 34;
  localparam int NRUN = 48;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        en, clr, bit_in, bit_vld, word_vld;
  logic [31:0] word;
  logic        f_ones, f_long, f_noise, f_stuck;

  int n_chk = 0;
  int n_fail = 0;
  int seen_ones = 0, seen_long = 0, seen_noise = 0, seen_stuck = 0;

  int          m_run, m_ones, m_cnt;
  bit          m_have, m_prev, m_have_w;
  logic [31:0] m_prev_w;
  bit          e_ones, e_long, e_noise, e_stuck;

  always #5 clk = ~clk;

  rng_health_mon dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .en_i           (en),
    .clr_i          (clr),
    .bit_i          (bit_in),
    .bit_vld_i      (bit_vld),
    .word_i         (word),
    .word_vld_i     (word_vld),
    .fail_ones_o    (f_ones),
    .fail_longrun_o (f_long),
    .fail_noise_o   (f_noise),
    .fail_stuck_o   (f_stuck)
  );

  task automatic check_eq(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic model_reset();
    m_run = 0; m_ones = 0; m_cnt = 0;
    m_have = 0; m_prev = 0; m_have_w = 0; m_prev_w = '0;
  endtask

  // expected pulses for the inputs presented this cycle
  task automatic model_eval();
    e_ones = 0; e_long = 0; e_noise = 0; e_stuck = 0;
    if (clr) begin
      model_reset();
    end else if (en) begin
      if (bit_vld) begin
        if (m_have && (bit_in == m_prev)) m_run++;
        else m_run = 1;
        m_have = 1;
        m_prev = bit_in;
        e_long  = (m_run == LRUN);
        e_noise = (m_run == NRUN);
        m_ones += int'(bit_in);
        m_cnt++;
        if (m_cnt == WIN) begin
          e_ones = (m_ones < LO) || (m_ones > HI);
          m_cnt = 0;
          m_ones = 0;
        end
      end
      if (word_vld) begin
        e_stuck = m_have_w && (word == m_prev_w);
        m_have_w = 1;
        m_prev_w = word;
      end
    end
  endtask

  task automatic cyc(input logic b, input logic bv, input logic [31:0] w,
                     input logic wv, input logic e, input logic c);
    @(negedge clk);
    bit_in = b; bit_vld = bv; word = w; word_vld = wv; en = e; clr = c;
    model_eval();
    @(posedge clk);
    #1;
    check_eq("R2 ones pulse", int'(f_ones), int'(e_ones));
    check_eq("R4 long-run pulse", int'(f_long), int'(e_long));
    check_eq("R5 noise pulse", int'(f_noise), int'(e_noise));
    check_eq("R7 stuck pulse", int'(f_stuck), int'(e_stuck));
    seen_ones += int'(f_ones);
    seen_long += int'(f_long);
    seen_noise += int'(f_noise);
    seen_stuck += int'(f_stuck);
  endtask

  task automatic bits(input logic b, input int n);
    for (int i = 0; i < n; i++) cyc(b, 1'b1, 32'h0, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic wrd(input logic [31:0] w);
    cyc(1'b0, 1'b0, w, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic do_clear();
    cyc(1'b0, 1'b0, 32'h0, 1'b0, 1'b1, 1'b1);
  endtask

  // one full window holding exactly k ones
  task automatic window(input int k);
    if (k <= WIN / 2) begin
      for (int i = 0; i < k; i++) begin bits(1'b1, 1); bits(1'b0, 1); end
      bits(1'b0, WIN - 2 * k);
    end else begin
      for (int i = 0; i < WIN - k; i++) begin bits(1'b0, 1); bits(1'b1, 1); end
      bits(1'b1, 2 * k - WIN);
    end
  endtask

  initial begin
    #(1_900_000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    int base;
    logic [31:0] lastw;
    void'($urandom(32'h5eed_c0de));
    rst_n = 1'b0; en = 0; clr = 0; bit_in = 0; bit_vld = 0; word = '0; word_vld = 0;
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    check_eq("R1 reset ones", int'(f_ones), 0);
    check_eq("R1 reset long", int'(f_long), 0);
    check_eq("R1 reset noise", int'(f_noise), 0);
    check_eq("R1 reset stuck", int'(f_stuck), 0);
    @(negedge clk);
    rst_n = 1'b1;
    cyc(1'b0, 1'b0, 32'h0, 1'b0, 1'b1, 1'b0);
    check_eq("R1 first cycle quiet", seen_ones + seen_long + seen_noise + seen_stuck, 0);

    // R4 / R5 / R11: one pulse each per long run
    do_clear();
    base = seen_long;
    bits(1'b1, LRUN);
    check_eq("R4 pulse at 34th bit", seen_long - base, 1);
    bits(1'b1, NRUN - LRUN);
    check_eq("R5 noise at 48th bit", seen_noise, 1);
    bits(1'b1, 20);
    check_eq("R11 long once per run", seen_long - base, 1);
    check_eq("R11 noise once per run", seen_noise, 1);

    // R6: a differing bit restarts the run
    base = seen_long;
    bits(1'b0, 1); bits(1'b1, LRUN - 1); bits(1'b0, 1); bits(1'b1, LRUN - 1);
    check_eq("R6 restart prevents pulse", seen_long - base, 0);

    // R9: disabled cycles hold the run and give no pulse
    bits(1'b0, 1);
    bits(1'b1, 20);
    base = seen_long;
    for (int i = 0; i < 30; i++) cyc(1'b1, 1'b1, 32'h77, 1'b1, 1'b0, 1'b0);
    check_eq("R9 no pulse while disabled", seen_long + seen_stuck - base, 0);
    bits(1'b1, LRUN - 21);
    check_eq("R9 run held while disabled", seen_long - base, 0);
    bits(1'b1, 1);
    check_eq("R9 run resumes after enable", seen_long - base, 1);

    // R10: clear restarts the run
    bits(1'b0, 1);
    bits(1'b1, 30);
    do_clear();
    base = seen_long;
    bits(1'b1, 10);
    check_eq("R10 clear restarts run", seen_long - base, 0);

    // R7 / R8: repeated words
    base = seen_stuck;
    wrd(32'hA5A5_0001);
    wrd(32'hA5A5_0001);
    check_eq("R7 repeat flagged", seen_stuck - base, 1);
    wrd(32'h1234_5678);
    check_eq("R7 differing word clean", seen_stuck - base, 1);
    do_clear();
    wrd(32'h1234_5678);
    check_eq("R8 first word after clear", seen_stuck - base, 1);
    wrd(32'h1234_5678);
    check_eq("R7 repeat after clear", seen_stuck - base, 2);

    // R2 / R3: window bounds
    do_clear();
    base = seen_ones;
    window(LO - 1);
    check_eq("R2 below low bound fails", seen_ones - base, 1);
    window(LO);
    check_eq("R3 next window restarts, low bound passes", seen_ones - base, 1);
    window(HI + 1);
    check_eq("R2 above high bound fails", seen_ones - base, 2);
    window(HI);
    check_eq("R2 high bound passes", seen_ones - base, 2);

    // mixed random traffic
    lastw = 32'h0;
    for (int i = 0; i < 8000; i++) begin
      int r;
      logic b, e, c, wv;
      logic [31:0] w;
      r  = int'($urandom_range(0, 99));
      b  = (i % 400 < 60) ? 1'b1 : logic'($urandom_range(0, 1));
      e  = (r >= 8);
      c  = (r == 0);
      wv = logic'($urandom_range(0, 1));
      w  = ($urandom_range(0, 3) == 0) ? lastw : $urandom;
      if (wv) lastw = w;
      cyc(b, logic'($urandom_range(0, 7) != 0), w, wv, e, c);
    end

    summary();
    $finish;
  end

endmodule